// File: doc/BRIEF.md
# Program Exception Classifier

This block sits behind instruction decode. It takes the class flags of one decoded instruction, together with the user-mode and floating-point-available bits of the machine state, and decides whether the instruction must raise a program-class exception or a floating-point-unavailable exception. A program exception has four kinds: illegal, privileged, trap and unimplemented. The block names the kind with a 3-bit code. For unimplemented operations that come from floating-point instructions it also sets a qualifier bit.

The decision is combinational. It goes through a fixed priority and is then registered. A flagged instruction presented with `insn_valid` high in cycle N produces a one-cycle strobe on `exc_valid` in cycle N+1, with the code and qualifier beside it.

The output register is a two-state machine:
- `ST_IDLE`: nothing is reported.
- `ST_RAISE`: a report is presented.

Transitions:
- `ST_IDLE` → `ST_RAISE` when the current input is flagged.
- `ST_RAISE` → `ST_RAISE` when the next instruction is also flagged.
- `ST_RAISE` → `ST_IDLE` when the next instruction is not flagged.
- Any state → `ST_IDLE` on reset.

Top module: `prog_exc_classifier`

## Requirements
- R1: An instruction flagged as belonging to the illegal class reports code 1 (illegal).
- R2: A special-register move or a device-register move that names an undefined register reports code 1 (illegal).
- R3: In user mode (`msr_user`=1) a privileged instruction reports code 2 (privileged). In supervisor mode the same instruction raises nothing.
- R4: In user mode a special-register move whose register number has bit index 4 set (weight 16, counting from the LSB) reports code 2, even when the register is undefined. Device-register moves are not subject to this rule.
- R5: A trap instruction reports code 3 (trap) only when `trap_hit`=1 and `trap_dbg_en`=0. Otherwise it raises nothing.
- R6: String load/store instructions, indexed device-register moves and the interface-ID read each report code 4 (unimplemented) with `exc_fp`=0.
- R7: A floating-point instruction (arithmetic, load, store or move) reports code 4 with `exc_fp`=1 when `msr_fp_avail`=1. It reports code 5 (fp-unavailable) with `exc_fp`=0 when `msr_fp_avail`=0. `exc_fp` is never 1 with any other code.
- R8: A defined instruction flagged as not implemented reports code 1 (illegal).
- R9: When several conditions match, exactly one code is reported. The order is privileged, then illegal, then unimplemented or fp-unavailable, then trap.
- R10: The report appears in the cycle after the instruction is presented. `exc_valid` is high for exactly one cycle per flagged instruction. While `exc_valid`=0, `exc_code`=0 and `exc_fp`=0. Flags presented with `insn_valid`=0 raise nothing.
- R11: During and right after reset, `exc_valid`=0, `exc_code`=0 and `exc_fp`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | A decoded instruction is present this cycle |
| cls_illegal | input | 1 | Instruction is in the illegal class |
| cls_priv | input | 1 | Instruction is privileged |
| cls_trap | input | 1 | Instruction is one of the two trap instructions |
| cls_string | input | 1 | String load/store instruction |
| cls_dev_idx | input | 1 | Indexed device-register move |
| cls_ifid_rd | input | 1 | Interface-ID read instruction |
| cls_fp | input | 1 | Floating-point instruction, including FP loads, stores and moves |
| cls_notimpl | input | 1 | Defined instruction that is not implemented |
| is_spr_move | input | 1 | Move to/from a special-purpose register |
| is_dev_move | input | 1 | Move to/from a device register |
| reg_num | input | 10 | Register number of the move |
| reg_undef | input | 1 | The named register is undefined |
| trap_hit | input | 1 | Trap condition evaluated true |
| trap_dbg_en | input | 1 | Trapping is enabled as a debug interrupt |
| msr_user | input | 1 | Machine state: user mode |
| msr_fp_avail | input | 1 | Machine state: floating point available |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_code | output | 3 | 0 none, 1 illegal, 2 privileged, 3 trap, 4 unimplemented, 5 fp-unavailable |
| exc_fp | output | 1 | Unimplemented exception caused by a floating-point instruction |

## Verification
The embedded assertions check the following on every cycle:
- the strobe and the code agree;
- the qualifier appears only with code 4;
- nothing is reported after a cycle without an instruction;
- a user-mode privileged instruction or protected register move always yields code 2;
- any trap or fp-unavailable report traces back to the right inputs one cycle earlier.

Some behaviour only the directed scenarios can show. These are the full priority order among overlapping conditions, the exemption of device-register moves from the register-number rule, the suppression of traps under debug, and the exact strobe length for back-to-back flagged instructions.

// File: rtl/prx_pkg.sv
`timescale 1ns/1ps
package prx_pkg;

    typedef enum logic [2:0] {
        EXC_NONE      = 3'd0,
        EXC_ILLEGAL   = 3'd1,
        EXC_PRIV      = 3'd2,
        EXC_TRAP      = 3'd3,
        EXC_UNIMPL    = 3'd4,
        EXC_FPUNAVAIL = 3'd5
    } exc_code_e;

    typedef struct packed {
        logic priv;
        logic illegal;
        logic unimpl;
        logic fpu;
        logic trap;
        logic fp_cause;
    } exc_cond_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_RAISE = 1'b1
    } out_state_e;

endpackage

// File: rtl/prx_cond_decode.sv
`timescale 1ns/1ps
module prx_cond_decode
    import prx_pkg::*;
#(
    parameter int REG_W    = 10,
    parameter int PRIV_BIT = 4
) (
    input  logic             insn_valid,
    input  logic             cls_illegal,
    input  logic             cls_priv,
    input  logic             cls_trap,
    input  logic             cls_string,
    input  logic             cls_dev_idx,
    input  logic             cls_ifid_rd,
    input  logic             cls_fp,
    input  logic             cls_notimpl,
    input  logic             is_spr_move,
    input  logic             is_dev_move,
    input  logic [REG_W-1:0] reg_num,
    input  logic             reg_undef,
    input  logic             trap_hit,
    input  logic             trap_dbg_en,
    input  logic             msr_user,
    input  logic             msr_fp_avail,
    output exc_cond_t        cond
);

    logic spr_protected;
    logic unused_reg_bits;

    // Only one bit of the register number matters for the privilege rule.
    assign spr_protected   = is_spr_move & reg_num[PRIV_BIT];
    assign unused_reg_bits = ^reg_num;

    always_comb begin
        cond = '0;
        if (insn_valid) begin
            cond.priv     = msr_user & (cls_priv | spr_protected);
            cond.illegal  = cls_illegal | cls_notimpl
                          | ((is_spr_move | is_dev_move) & reg_undef);
            cond.fp_cause = cls_fp & msr_fp_avail;
            cond.unimpl   = cls_string | cls_dev_idx | cls_ifid_rd
                          | (cls_fp & msr_fp_avail);
            cond.fpu      = cls_fp & ~msr_fp_avail;
            cond.trap     = cls_trap & trap_hit & ~trap_dbg_en;
        end
    end

endmodule

// File: rtl/prx_prio_select.sv
`timescale 1ns/1ps
module prx_prio_select
    import prx_pkg::*;
(
    input  exc_cond_t cond,
    output logic      raise,
    output exc_code_e code,
    output logic      fp_qual
);

    always_comb begin
        raise   = 1'b1;
        fp_qual = 1'b0;
        code    = EXC_NONE;
        if (cond.priv) begin
            code = EXC_PRIV;
        end else if (cond.illegal) begin
            code = EXC_ILLEGAL;
        end else if (cond.unimpl) begin
            code    = EXC_UNIMPL;
            fp_qual = cond.fp_cause;
        end else if (cond.fpu) begin
            code = EXC_FPUNAVAIL;
        end else if (cond.trap) begin
            code = EXC_TRAP;
        end else begin
            raise = 1'b0;
        end
    end

endmodule

// File: rtl/prx_out_fsm.sv
`timescale 1ns/1ps
module prx_out_fsm
    import prx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raise,
    input  exc_code_e  code_in,
    input  logic       fp_in,
    output logic       exc_valid,
    output logic [2:0] exc_code,
    output logic       exc_fp
);

    out_state_e state_q, state_d;
    exc_code_e  code_q;
    logic       fp_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = raise ? ST_RAISE : ST_IDLE;
            ST_RAISE: state_d = raise ? ST_RAISE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= EXC_NONE;
            fp_q   <= 1'b0;
        end else if (raise) begin
            code_q <= code_in;
            fp_q   <= fp_in;
        end else begin
            code_q <= EXC_NONE;
            fp_q   <= 1'b0;
        end
    end

    assign exc_valid = (state_q == ST_RAISE);
    assign exc_code  = code_q;
    assign exc_fp    = fp_q;

    a_r10_code_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code != EXC_NONE));
    a_r10_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_code == EXC_NONE && !exc_fp));
    a_r7_qualifier_only_unimpl: assert property (@(posedge clk) disable iff (!rst_n)
        exc_fp |-> (exc_code == EXC_UNIMPL));

endmodule

// File: rtl/prog_exc_classifier.sv
`timescale 1ns/1ps
module prog_exc_classifier
    import prx_pkg::*;
#(
    parameter int REG_W    = 10,
    parameter int PRIV_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  logic             cls_illegal,
    input  logic             cls_priv,
    input  logic             cls_trap,
    input  logic             cls_string,
    input  logic             cls_dev_idx,
    input  logic             cls_ifid_rd,
    input  logic             cls_fp,
    input  logic             cls_notimpl,
    input  logic             is_spr_move,
    input  logic             is_dev_move,
    input  logic [REG_W-1:0] reg_num,
    input  logic             reg_undef,
    input  logic             trap_hit,
    input  logic             trap_dbg_en,
    input  logic             msr_user,
    input  logic             msr_fp_avail,
    output logic             exc_valid,
    output logic [2:0]       exc_code,
    output logic             exc_fp
);

    exc_cond_t cond;
    logic      raise;
    exc_code_e sel_code;
    logic      sel_fp;

    prx_cond_decode #(.REG_W(REG_W), .PRIV_BIT(PRIV_BIT)) u_decode (
        .insn_valid   (insn_valid),
        .cls_illegal  (cls_illegal),
        .cls_priv     (cls_priv),
        .cls_trap     (cls_trap),
        .cls_string   (cls_string),
        .cls_dev_idx  (cls_dev_idx),
        .cls_ifid_rd  (cls_ifid_rd),
        .cls_fp       (cls_fp),
        .cls_notimpl  (cls_notimpl),
        .is_spr_move  (is_spr_move),
        .is_dev_move  (is_dev_move),
        .reg_num      (reg_num),
        .reg_undef    (reg_undef),
        .trap_hit     (trap_hit),
        .trap_dbg_en  (trap_dbg_en),
        .msr_user     (msr_user),
        .msr_fp_avail (msr_fp_avail),
        .cond         (cond)
    );

    prx_prio_select u_select (
        .cond    (cond),
        .raise   (raise),
        .code    (sel_code),
        .fp_qual (sel_fp)
    );

    prx_out_fsm u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise     (raise),
        .code_in   (sel_code),
        .fp_in     (sel_fp),
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .exc_fp    (exc_fp)
    );

    a_r10_idle_without_insn: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !exc_valid);
    a_r3_user_privileged: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && msr_user && cls_priv) |=> (exc_valid && exc_code == EXC_PRIV));
    a_r4_protected_spr: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && msr_user && is_spr_move && reg_num[PRIV_BIT])
        |=> (exc_code == EXC_PRIV));
    a_r5_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_code == EXC_TRAP) |-> $past(cls_trap && trap_hit && !trap_dbg_en));
    a_r7_fpu_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_code == EXC_FPUNAVAIL) |-> $past(cls_fp && !msr_fp_avail));

endmodule

// File: tb/tb_prog_exc_classifier.sv
`timescale 1ns/1ps
module tb_prog_exc_classifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_valid, cls_illegal, cls_priv, cls_trap, cls_string;
    logic       cls_dev_idx, cls_ifid_rd, cls_fp, cls_notimpl;
    logic       is_spr_move, is_dev_move, reg_undef, trap_hit, trap_dbg_en;
    logic       msr_user, msr_fp_avail;
    logic [9:0] reg_num;
    logic       exc_valid;
    logic [2:0] exc_code;
    logic       exc_fp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    prog_exc_classifier dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
        .cls_illegal(cls_illegal), .cls_priv(cls_priv), .cls_trap(cls_trap),
        .cls_string(cls_string), .cls_dev_idx(cls_dev_idx),
        .cls_ifid_rd(cls_ifid_rd), .cls_fp(cls_fp), .cls_notimpl(cls_notimpl),
        .is_spr_move(is_spr_move), .is_dev_move(is_dev_move),
        .reg_num(reg_num), .reg_undef(reg_undef), .trap_hit(trap_hit),
        .trap_dbg_en(trap_dbg_en), .msr_user(msr_user),
        .msr_fp_avail(msr_fp_avail), .exc_valid(exc_valid),
        .exc_code(exc_code), .exc_fp(exc_fp)
    );

    task automatic chk(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic clear_in();
        insn_valid = 0; cls_illegal = 0; cls_priv = 0; cls_trap = 0;
        cls_string = 0; cls_dev_idx = 0; cls_ifid_rd = 0; cls_fp = 0;
        cls_notimpl = 0; is_spr_move = 0; is_dev_move = 0; reg_num = '0;
        reg_undef = 0; trap_hit = 0; trap_dbg_en = 0; msr_user = 0;
        msr_fp_avail = 0;
    endtask

    // Present the prepared flags for one cycle, check the report, then
    // check that the strobe has dropped again.
    task automatic fire(int exp_code, int exp_fp, string req, bit valid_in = 1'b1);
        insn_valid = valid_in;
        @(negedge clk);
        clear_in();
        chk({req, " valid"}, exc_valid, (exp_code != 0) ? 1 : 0);
        chk({req, " code"}, exc_code, exp_code);
        chk({req, " fp"}, exc_fp, exp_fp);
        @(negedge clk);
        chk({req, " strobe drops"}, exc_valid, 0);
    endtask

    task automatic t_reset();
        chk("R11 valid", exc_valid, 0);
        chk("R11 code", exc_code, 0);
        chk("R11 fp", exc_fp, 0);
    endtask

    task automatic t_illegal();
        cls_illegal = 1; fire(1, 0, "R1 illegal class");
        cls_illegal = 1; fire(0, 0, "R10 no insn_valid", 1'b0);
    endtask

    task automatic t_undef_move();
        is_spr_move = 1; reg_undef = 1; reg_num = 10'd3;
        fire(1, 0, "R2 undefined spr");
        is_dev_move = 1; reg_undef = 1; reg_num = 10'd16; msr_user = 1;
        fire(1, 0, "R2 R4 undefined dev move in user");
        is_spr_move = 1; reg_num = 10'd26;
        fire(0, 0, "R4 supervisor spr bit set");
    endtask

    task automatic t_priv();
        msr_user = 1; cls_priv = 1; fire(2, 0, "R3 user privileged");
        cls_priv = 1; fire(0, 0, "R3 supervisor privileged");
    endtask

    task automatic t_spr_bit();
        msr_user = 1; is_spr_move = 1; reg_num = 10'd48; reg_undef = 1;
        fire(2, 0, "R4 undefined protected spr");
        msr_user = 1; is_spr_move = 1; reg_num = 10'd8;
        fire(0, 0, "R4 user spr bit clear");
        msr_user = 1; is_spr_move = 1; reg_num = 10'd26;
        fire(2, 0, "R4 user spr bit set");
    endtask

    task automatic t_trap();
        cls_trap = 1; trap_hit = 1; fire(3, 0, "R5 trap taken");
        cls_trap = 1; trap_hit = 1; trap_dbg_en = 1; fire(0, 0, "R5 trap to debug");
        cls_trap = 1; fire(0, 0, "R5 trap condition false");
    endtask

    task automatic t_unimpl();
        cls_string = 1;  fire(4, 0, "R6 string op");
        cls_dev_idx = 1; fire(4, 0, "R6 indexed dev move");
        cls_ifid_rd = 1; fire(4, 0, "R6 interface id read");
    endtask

    task automatic t_fp();
        cls_fp = 1; msr_fp_avail = 1; fire(4, 1, "R7 fp available");
        cls_fp = 1; fire(5, 0, "R7 fp unavailable");
    endtask

    task automatic t_notimpl();
        cls_notimpl = 1; fire(1, 0, "R8 not implemented");
    endtask

    task automatic t_priority();
        msr_user = 1; cls_priv = 1; cls_illegal = 1; cls_string = 1;
        fire(2, 0, "R9 priv over illegal");
        cls_illegal = 1; cls_string = 1; cls_trap = 1; trap_hit = 1;
        fire(1, 0, "R9 illegal over unimpl");
        cls_fp = 1; cls_trap = 1; trap_hit = 1;
        fire(5, 0, "R9 fpu over trap");
        cls_string = 1; cls_trap = 1; trap_hit = 1;
        fire(4, 0, "R9 unimpl over trap");
        cls_notimpl = 1; cls_fp = 1; msr_fp_avail = 1;
        fire(1, 0, "R9 illegal hides fp qualifier");
    endtask

    task automatic t_strobe();
        cls_illegal = 1; insn_valid = 1;
        @(negedge clk);
        clear_in(); cls_trap = 1; trap_hit = 1; insn_valid = 1;
        chk("R10 first of pair valid", exc_valid, 1);
        chk("R10 first of pair code", exc_code, 1);
        @(negedge clk);
        clear_in();
        chk("R10 second of pair valid", exc_valid, 1);
        chk("R10 second of pair code", exc_code, 3);
        @(negedge clk);
        chk("R10 pair strobe ends", exc_valid, 0);
        chk("R10 pair code clears", exc_code, 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_in();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_illegal();
        t_undef_move();
        t_priv();
        t_spr_bit();
        t_trap();
        t_unimpl();
        t_fp();
        t_notimpl();
        t_priority();
        t_strobe();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule